// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an ADC conversion controller starts a conversion. It does not make that decision from software. Eight trigger flags arrive from the neighbouring peripherals. A 3-bit field in a small control register picks one of them, and the block watches that flag for a low-to-high transition. The flag at index 0 is the converter's own conversion-complete flag, which gives a free-running mode. The other seven come from the analog comparator, external interrupt 0, and several timer events.

The edge detector sits behind the source multiplexer. If the selection moves from a flag that is low to a flag that is high, the multiplexed signal rises, and that counts as a trigger. The one exception is a move into free-running mode, which never fires on its own. A detected edge becomes a single-cycle `start_conv` pulse only when both the auto-trigger enable and the converter enable are set.

The control register is written through a plain write strobe and can be read back at any time. Its top bits are reserved and always read as zero.

Top module: `adc_trig_select`

## Requirements
- R1: `rd_data[2:0]` selects the source, and the flag watched is `trig_flags[sel]`. The codes are: 0 conversion complete (free running), 1 analog comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 1 compare B, 6 timer 1 overflow, 7 timer 1 capture. Flags that are not selected never cause a pulse.
- R2: A pulse follows only a rising edge of the selected flag. Holding the flag high gives exactly one pulse.
- R3: While the auto-trigger enable (control bit 3) is 0, no pulse is produced, whatever the selection and flag activity.
- R4: Changing the selection from a source whose flag is low to one whose flag is high produces one pulse.
- R5: While the converter enable (control bit 4) is 0, no pulse is produced.
- R6: Writing the selection to 0 from any other code produces no pulse, even when `trig_flags[0]` is high.
- R7: Control bits 7:5 are reserved. Writing ones to them has no effect, and they always read as 0.
- R8: `start_conv` rises on the clock edge that samples the new flag (or selection) level, and it lasts exactly one cycle.
- R9: Reset clears the control register and the edge history, and no pulse appears out of reset.
- R10: With selection 0 and both enables set, each rising edge of `trig_flags[0]` produces one pulse.
- R11: Setting the auto-trigger enable while the selected flag is already high produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: [2:0] source select, [3] auto-trigger enable, [4] converter enable, [7:5] reserved |
| trig_flags | input | 8 | Candidate trigger flags; index 0 is the conversion-complete flag |
| rd_data | output | 8 | Control register read-back, with bits 7:5 reading 0 |
| start_conv | output | 1 | One-cycle start-conversion pulse |

## Verification
The assertions assume that `trig_flags`, `wr_en` and `wr_data` are synchronous to `clk`, so that each flag holds one value for a whole cycle. They also assume that the control value read back on `rd_data` is the selection the multiplexer used in that same cycle. The bench keeps to these assumptions: it changes flags and write data only on the falling clock edge, and it raises the write strobe for a single cycle at a time. The bench never toggles a flag and rewrites the selection in the same cycle, so every expected pulse can be traced to one cause.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);
  localparam int unsigned REG_W   = 8;
  localparam int unsigned AUTO_BIT = SEL_W;
  localparam int unsigned CONV_BIT = SEL_W + 1;
  localparam int unsigned USED_W   = SEL_W + 2;

  typedef struct packed {
    logic             conv_en;
    logic             auto_en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/adc_trig_rst_sync.sv
module adc_trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/adc_trig_ctrl_reg.sv
module adc_trig_ctrl_reg
  import adc_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rd_data
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.sel     = wr_data[SEL_W-1:0];
      ctrl_d.auto_en = wr_data[AUTO_BIT];
      ctrl_d.conv_en = wr_data[CONV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  // reserved upper bits are not stored and read back as zero
  assign rd_data = {{(REG_W-USED_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [SEL_W-1:0]   sel,
  input  logic               arm,
  output logic               start
);
  logic             sel_flag;
  logic             flag_q;
  logic [SEL_W-1:0] sel_q;
  logic             start_q;
  logic             fr_switch;
  logic             start_d;

  assign sel_flag = flags[sel];

  always_comb begin
    // moving into free-running selection must not count as an edge
    fr_switch = (sel == '0) && (sel_q != '0);
    start_d   = arm && sel_flag && !flag_q && !fr_switch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      sel_q   <= '0;
      start_q <= 1'b0;
    end else begin
      flag_q  <= sel_flag;
      sel_q   <= sel;
      start_q <= start_d;
    end
  end

  assign start = start_q;
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
  import adc_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] trig_flags,
  output logic [REG_W-1:0]   rd_data,
  output logic               start_conv
);
  logic  rst_n_int;
  ctrl_t ctrl;

  adc_trig_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_an     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  adc_trig_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .rd_data (rd_data)
  );

  adc_trig_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n_int),
    .flags (trig_flags),
    .sel   (ctrl.sel),
    .arm   (ctrl.auto_en && ctrl.conv_en),
    .start (start_conv)
  );
endmodule

// File: rtl/adc_trig_select_chk.sv
module adc_trig_select_chk
  import adc_trig_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [NUM_SRC-1:0] trig_flags,
  input logic [REG_W-1:0]   rd_data,
  input logic               start_conv
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  a_r5_gated_by_enables: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> ($past(rd_data[AUTO_BIT]) && $past(rd_data[CONV_BIT])));

  a_r2_selected_flag_high: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> $past(trig_flags[rd_data[SEL_W-1:0]]));

  a_r6_no_fr_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_conv && ($past(rd_data[SEL_W-1:0]) == '0)) |-> ($past(rd_data[SEL_W-1:0], 2) == '0));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[REG_W-1:USED_W] == '0));
endmodule

bind adc_trig_select adc_trig_select_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .trig_flags (trig_flags),
  .rd_data    (rd_data),
  .start_conv (start_conv)
);

// File: tb/tb_adc_trig_select.sv
module tb_adc_trig_select;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] trig_flags;
  logic [7:0] rd_data;
  logic       start_conv;

  int unsigned n_checks;
  int unsigned n_errors;

  adc_trig_select dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .trig_flags (trig_flags),
    .rd_data    (rd_data),
    .start_conv (start_conv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {sel[2:0], pulsed flag index[2:0], expected pulse}
  localparam logic [6:0] VEC [16] = '{
    {3'd1, 3'd1, 1'b1}, {3'd1, 3'd2, 1'b0},
    {3'd2, 3'd2, 1'b1}, {3'd2, 3'd0, 1'b0},
    {3'd3, 3'd3, 1'b1}, {3'd3, 3'd4, 1'b0},
    {3'd4, 3'd4, 1'b1}, {3'd4, 3'd7, 1'b0},
    {3'd5, 3'd5, 1'b1}, {3'd5, 3'd6, 1'b0},
    {3'd6, 3'd6, 1'b1}, {3'd6, 3'd1, 1'b0},
    {3'd7, 3'd7, 1'b1}, {3'd7, 3'd3, 1'b0},
    {3'd0, 3'd0, 1'b1}, {3'd0, 3'd5, 1'b0}
  };

  task automatic chk1(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: start_conv=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #200000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; trig_flags = 8'hFF;
    repeat (3) tick();
    rst_n = 1'b1;
    // R9: out of reset, register clear and no pulse despite high flags
    for (int i = 0; i < 4; i++) begin
      tick();
      chk1(start_conv, 1'b0, "R9");
    end
    chk8(rd_data, 8'h00, "R9");
    trig_flags = '0;

    // R7: reserved bits ignored
    wr(8'hE5);
    chk8(rd_data, 8'h05, "R7");
    wr(8'h00);

    // R1, R8: vector table over every source code
    foreach (VEC[k]) begin
      wr({3'b000, 1'b1, 1'b1, VEC[k][6:4]});
      tick();
      trig_flags = 8'(1) << VEC[k][3:1];
      tick();
      chk1(start_conv, VEC[k][0], "R1");
      trig_flags = '0;
      tick();
      chk1(start_conv, 1'b0, "R8");
    end

    // R2: held level gives one pulse
    wr(8'h1B);
    trig_flags = 8'h08;
    tick(); chk1(start_conv, 1'b1, "R2");
    tick(); chk1(start_conv, 1'b0, "R2");
    tick(); chk1(start_conv, 1'b0, "R2");
    trig_flags = '0;

    // R3: auto-trigger disabled
    wr(8'h13);
    tick();
    trig_flags = 8'h08; tick(); chk1(start_conv, 1'b0, "R3");
    trig_flags = 8'h00; tick();
    trig_flags = 8'h08; tick(); chk1(start_conv, 1'b0, "R3");
    trig_flags = '0;

    // R5: converter disabled
    wr(8'h0B);
    tick();
    trig_flags = 8'h08; tick(); chk1(start_conv, 1'b0, "R5");
    trig_flags = '0;

    // R4: switching from a low flag to a high flag
    wr(8'h19);
    trig_flags = 8'h04;
    tick(); tick();
    wr(8'h1A);
    chk1(start_conv, 1'b0, "R4");
    tick(); chk1(start_conv, 1'b1, "R4");
    tick(); chk1(start_conv, 1'b0, "R4");

    // R6: switch into free-running with conversion flag high
    trig_flags = 8'h01;
    tick(); tick();
    wr(8'h18);
    chk1(start_conv, 1'b0, "R6");
    tick(); chk1(start_conv, 1'b0, "R6");
    tick(); chk1(start_conv, 1'b0, "R6");

    // R10: free-running re-trigger on conversion-complete edge
    trig_flags = 8'h00; tick();
    trig_flags = 8'h01; tick(); chk1(start_conv, 1'b1, "R10");
    trig_flags = 8'h00; tick(); chk1(start_conv, 1'b0, "R10");
    trig_flags = 8'h01; tick(); chk1(start_conv, 1'b1, "R10");
    trig_flags = '0;

    // R11: enabling while the selected flag is already high
    wr(8'h15);
    trig_flags = 8'h20;
    tick(); tick();
    wr(8'h1D);
    chk1(start_conv, 1'b0, "R11");
    tick(); chk1(start_conv, 1'b0, "R11");
    tick(); chk1(start_conv, 1'b0, "R11");
    trig_flags = '0;

    // R9: asynchronous reset mid-run clears the register
    rst_n = 1'b0;
    tick();
    chk8(rd_data, 8'h00, "R9");
    rst_n = 1'b1;
    repeat (3) tick();
    chk1(start_conv, 1'b0, "R9");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule